// File: doc/BRIEF.md
# Reset Cause Register

This block keeps a small set of sticky flags that tell software which kind of reset last reached the system. Four event inputs arrive as single-cycle pulses from reset detection logic elsewhere: a power-up event, an external reset pin event, a supply-dip event and a timeout-monitor event. Each pulse sets its own flag. The flags stay set until a defined clear condition occurs.

Software reads the flags through a registered read port as one byte. It clears flags by writing zero to the matching bits of the write port. A power-up event wipes the three non-power flags. The power-up flag itself is cleared only by software. The ordinary system reset leaves the flag storage alone, so the cause of a reset can still be read after that reset has run.

Top module: `rstcause_reg`

## Requirements
- R1: A pulse on `pwr_evt` sets flag bit 0 of `cause_flags` at the next clock edge.
- R2: Pulses on `pin_evt`, `brn_evt` and `dog_evt` set flag bits 1, 2 and 3 of `cause_flags` at the next clock edge.
- R3: A pulse on `pwr_evt` clears flag bits 1 to 3 at the same edge, unless that bit's own event is also present in that cycle.
- R4: Flag bit 0 can be cleared only by a software write. Neither a power-up event nor `rst` clears it.
- R5: A cycle with `bus_wr_en` high clears every flag whose bit in `bus_wdata` is 0. A bit written as 1 leaves its flag unchanged.
- R6: When a flag's set event and a software clear of that flag occur in the same cycle, the flag ends up set.
- R7: `rst` does not change `cause_flags`. While `rst` is high, `bus_rdata` reads 0 at the next edge.
- R8: When `bus_rd_en` is high at an edge, `bus_rdata` holds the flags as they were before that edge, in bits 3:0, with bits 7:4 zero. When `bus_rd_en` is low, `bus_rdata` is 0.
- R9: If no event occurs and no clearing write occurs, all flags keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset; affects only the read register |
| pwr_evt | input | 1 | Power-up reset event pulse |
| pin_evt | input | 1 | External reset pin event pulse |
| brn_evt | input | 1 | Supply-dip reset event pulse |
| dog_evt | input | 1 | Timeout-monitor reset event pulse |
| bus_wr_en | input | 1 | Write strobe for the clear operation |
| bus_wdata | input | 4 | Write data; a 0 bit clears that flag |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data (flags in bits 3:0) |
| cause_flags | output | 4 | Live flag values: bit0 power-up, bit1 pin, bit2 supply-dip, bit3 timeout |

## Verification
The bench drives single events, event pairs, and a power-up event that coincides with other events. These patterns separate the power-up flag's clear rule from the rule shared by the other three flags. Writes of all ones and writes of selective zeros show which clear paths a write opens. An event that arrives in the same cycle as a clearing write exposes any priority inversion. The bench also pulses the system reset while flags are set and reads the flags afterwards. This shows whether the storage survives that reset, and it distinguishes the flag storage from the read register, which the reset does clear.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;

    localparam int FLAG_W = 4;
    localparam int BUS_W  = 8;
    localparam int PAD_W  = BUS_W - FLAG_W;

    typedef enum int {
        IDX_PWR = 0,
        IDX_PIN = 1,
        IDX_BRN = 2,
        IDX_DOG = 3
    } flag_idx_e;

    // Packed so that the power-up event lands at bit 0.
    typedef struct packed {
        logic dog;
        logic brn;
        logic pin;
        logic pwr;
    } evt_vec_t;

    function automatic logic wiped_by_pwr(int idx);
        return idx != IDX_PWR;
    endfunction

    function automatic logic [BUS_W-1:0] to_bus(logic [FLAG_W-1:0] f);
        return {{PAD_W{1'b0}}, f};
    endfunction

endpackage

// File: rtl/rstcause_cell.sv
module rstcause_cell (
    input  logic clk,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // No reset term: clearing is driven entirely by clr_i.
    always_ff @(posedge clk) begin
        if (set_i)
            q_o <= 1'b1;
        else if (clr_i)
            q_o <= 1'b0;
    end
endmodule

// File: rtl/rstcause_bank.sv
module rstcause_bank
    import rstcause_pkg::*;
(
    input  logic              clk,
    input  evt_vec_t          evt_i,
    input  logic              wr_en_i,
    input  logic [FLAG_W-1:0] wdata_i,
    output logic [FLAG_W-1:0] flags_o
);
    logic [FLAG_W-1:0] set_v;
    logic [FLAG_W-1:0] clr_v;

    assign set_v = evt_i;

    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        if (wiped_by_pwr(i)) begin : g_wipe
            assign clr_v[i] = evt_i.pwr | (wr_en_i & ~wdata_i[i]);
        end else begin : g_keep
            assign clr_v[i] = wr_en_i & ~wdata_i[i];
        end
        rstcause_cell u_cell (
            .clk   (clk),
            .set_i (set_v[i]),
            .clr_i (clr_v[i]),
            .q_o   (flags_o[i])
        );
    end
endmodule

// File: rtl/rstcause_rdport.sv
module rstcause_rdport
    import rstcause_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [BUS_W-1:0]  rdata_o
);
    always_ff @(posedge clk) begin
        if (rst)
            rdata_o <= '0;
        else if (rd_en_i)
            rdata_o <= to_bus(flags_i);
        else
            rdata_o <= '0;
    end
endmodule

// File: rtl/rstcause_reg.sv
module rstcause_reg
    import rstcause_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_evt,
    input  logic              pin_evt,
    input  logic              brn_evt,
    input  logic              dog_evt,
    input  logic              bus_wr_en,
    input  logic [FLAG_W-1:0] bus_wdata,
    input  logic              bus_rd_en,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [FLAG_W-1:0] cause_flags
);
    evt_vec_t evt;

    always_comb begin
        evt.pwr = pwr_evt;
        evt.pin = pin_evt;
        evt.brn = brn_evt;
        evt.dog = dog_evt;
    end

    rstcause_bank u_bank (
        .clk     (clk),
        .evt_i   (evt),
        .wr_en_i (bus_wr_en),
        .wdata_i (bus_wdata),
        .flags_o (cause_flags)
    );

    rstcause_rdport u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en_i (bus_rd_en),
        .flags_i (cause_flags),
        .rdata_o (bus_rdata)
    );
endmodule

// File: rtl/rstcause_reg_chk.sv
module rstcause_reg_chk (
    input logic       clk,
    input logic       rst,
    input logic       pwr_evt,
    input logic       pin_evt,
    input logic       brn_evt,
    input logic       dog_evt,
    input logic       bus_wr_en,
    input logic [3:0] bus_wdata,
    input logic       bus_rd_en,
    input logic [7:0] bus_rdata,
    input logic [3:0] cause_flags
);
    assert_pwr_sets_R1: assert property (@(posedge clk) disable iff (rst)
        pwr_evt |=> cause_flags[0]);

    assert_pin_sets_R2: assert property (@(posedge clk) disable iff (rst)
        pin_evt |=> cause_flags[1]);
    assert_brn_sets_R2: assert property (@(posedge clk) disable iff (rst)
        brn_evt |=> cause_flags[2]);
    assert_dog_sets_R2: assert property (@(posedge clk) disable iff (rst)
        dog_evt |=> cause_flags[3]);

    assert_pwr_wipes_R3: assert property (@(posedge clk) disable iff (rst)
        (pwr_evt && !pin_evt && !brn_evt && !dog_evt) |=> (cause_flags[3:1] == 3'b000));

    assert_pwr_bit_kept_R4: assert property (@(posedge clk) disable iff (rst)
        (cause_flags[0] && !(bus_wr_en && !bus_wdata[0])) |=> cause_flags[0]);

    assert_wr_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && !bus_wdata[1] && !pin_evt) |=> !cause_flags[1]);

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && !bus_wdata[2] && brn_evt) |=> cause_flags[2]);

    assert_read_value_R8: assert property (@(posedge clk) disable iff (rst)
        bus_rd_en |=> (bus_rdata == {4'b0000, $past(cause_flags)}));

    assert_read_pad_R8: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[7:4] == 4'b0000);

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!pwr_evt && !pin_evt && !brn_evt && !dog_evt && (!bus_wr_en || (&bus_wdata)))
        |=> $stable(cause_flags));
endmodule

bind rstcause_reg rstcause_reg_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pwr_evt     (pwr_evt),
    .pin_evt     (pin_evt),
    .brn_evt     (brn_evt),
    .dog_evt     (dog_evt),
    .bus_wr_en   (bus_wr_en),
    .bus_wdata   (bus_wdata),
    .bus_rd_en   (bus_rd_en),
    .bus_rdata   (bus_rdata),
    .cause_flags (cause_flags)
);

// File: tb/rstcause_reg_tb.sv
module rstcause_reg_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_evt = 1'b0, pin_evt = 1'b0, brn_evt = 1'b0, dog_evt = 1'b0;
    logic       bus_wr_en = 1'b0;
    logic [3:0] bus_wdata = 4'h0;
    logic       bus_rd_en = 1'b0;
    logic [7:0] bus_rdata;
    logic [3:0] cause_flags;

    always #10 clk = ~clk; // 50 MHz

    rstcause_reg u_dut (
        .clk(clk), .rst(rst),
        .pwr_evt(pwr_evt), .pin_evt(pin_evt), .brn_evt(brn_evt), .dog_evt(dog_evt),
        .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en),
        .bus_rdata(bus_rdata), .cause_flags(cause_flags)
    );

    typedef struct {
        logic [3:0] flags;
        logic [7:0] rdata;
        string      req;
    } exp_t;

    exp_t       sb[$];
    logic [3:0] model = 4'bxxxx;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    // Driver: evt bit0 power-up, bit1 pin, bit2 supply-dip, bit3 timeout.
    task automatic step(input logic [3:0] evt, input logic we, input logic [3:0] wd,
                        input logic rd, input string req);
        exp_t       e;
        logic [3:0] nxt;
        @(negedge clk);
        pwr_evt = evt[0]; pin_evt = evt[1]; brn_evt = evt[2]; dog_evt = evt[3];
        bus_wr_en = we; bus_wdata = wd; bus_rd_en = rd;
        e.rdata = (!rst && rd) ? {4'b0000, model} : 8'h00;
        for (int i = 0; i < 4; i++) begin
            if (evt[i])                         nxt[i] = 1'b1;
            else if ((i != 0) && evt[0])        nxt[i] = 1'b0;
            else if (we && !wd[i])              nxt[i] = 1'b0;
            else                                nxt[i] = model[i];
        end
        model   = nxt;
        e.flags = nxt;
        e.req   = req;
        sb.push_back(e);
    endtask

    // Monitor: compare two time units after each edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                total++;
                if (cause_flags !== e.flags || bus_rdata !== e.rdata) begin
                    bad++;
                    $display("FAIL %s: flags=%b rdata=%h expected flags=%b rdata=%h",
                             e.req, cause_flags, bus_rdata, e.flags, e.rdata);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        step(4'b0001, 0, 4'h0, 0, "R1 power-up in reset");
        step(4'b0000, 0, 4'h0, 1, "R7 read during reset gives 0");
        @(negedge clk); rst = 1'b0;
        step(4'b0000, 0, 4'h0, 1, "R8 read reset state");
        step(4'b0010, 0, 4'h0, 0, "R2 pin event");
        step(4'b0100, 0, 4'h0, 0, "R2 supply-dip event");
        step(4'b1000, 0, 4'h0, 1, "R2 timeout event");
        step(4'b0000, 0, 4'h0, 1, "R8 read all set");
        @(negedge clk); rst = 1'b1;
        step(4'b0000, 0, 4'h0, 1, "R7 reset keeps flags");
        @(negedge clk); rst = 1'b0;
        step(4'b0000, 1, 4'hF, 0, "R5 write ones no effect");
        step(4'b0000, 1, 4'b1101, 1, "R5 write zero clears pin");
        step(4'b0000, 0, 4'h0, 0, "R9 hold");
        step(4'b0001, 0, 4'h0, 1, "R3 power-up wipes others");
        step(4'b0110, 0, 4'h0, 0, "R2 pin and dip together");
        step(4'b0101, 0, 4'h0, 0, "R3 power-up with dip kept");
        step(4'b0001, 0, 4'h0, 0, "R4 power-up keeps bit0");
        step(4'b0000, 1, 4'b1110, 1, "R4 write clears bit0");
        step(4'b0010, 1, 4'h0, 0, "R6 set wins over clear");
        step(4'b1000, 1, 4'b0111, 0, "R6 timeout set wins");
        step(4'b0000, 1, 4'h0, 1, "R5 write all zero");
        step(4'b0000, 0, 4'h0, 1, "R8 read cleared");
        step(4'b0000, 0, 4'h0, 0, "R9 idle hold");
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule